// File: doc/BRIEF.md
# I2C Line Conditioner and Bus Condition Monitor

This block sits between the two raw open-drain lines of an I2C bus and the rest of an I2C controller. Each line is first brought into the system clock domain by a short flop chain, then cleaned by a digital deglitcher whose acceptance window can be set from 1 to 256 system clocks. The cleaned lines drive one-cycle strobes for SCL edges and for start and stop conditions. From these strobes the block keeps a bus-busy flag and a bit counter. The counter is used to spot protocol violations: a start or stop that falls inside a byte plus its acknowledge bit.

A bus-activity watchdog counts how long SCL holds one level while the bus is busy. It raises a timeout when that time reaches a programmable 32-bit preset. Three sticky status bits (stop seen, bus error, timeout) are held until the controller writes a one to the matching clear input. The integrating register block is expected to reset the filter-width field to 4 and the timeout preset to 100,000,000 clocks. Both arrive here as plain inputs.

Top module: `i2cmon_top`

## Requirements
- R1: Each filtered line resets high. It takes a new value only after the raw line has held that value at the filter input for `filt_width` consecutive clocks. The filter input lags the raw pin by the 2-flop synchronizer, so a clean level change shows at the output 2 + `filt_width` clocks after it reaches the pin.
- R2: A raw excursion shorter than the filter width leaves the filtered line unchanged.
- R3: A `filt_width` value of 0 selects the widest window, 256 clocks.
- R4: An SDA fall while filtered SCL is high gives exactly one start strobe cycle. An SDA rise while filtered SCL is high gives exactly one stop strobe cycle. Each filtered SCL edge gives exactly one rise or fall strobe cycle.
- R5: `bus_busy` goes high the cycle after a start strobe. It goes low the cycle after a stop strobe.
- R6: Every stop condition sets the sticky `stat_stop` bit.
- R7: Within a busy frame, the block counts SCL rising edges. The count starts at a start or repeated start, and it returns to zero on the SCL fall that ends the ninth bit. A start or stop seen while this count is between 2 and 9 sets the sticky `stat_berr`. At a count of 0 or 1, such a condition is legal.
- R8: While `to_enable` is high and the bus is busy, SCL holding one level for `to_preset` clocks sets the sticky `stat_tmo`. No timeout is flagged when `to_enable` is low, or when SCL toggles faster than the preset.
- R9: A one on `clr_stop`, `clr_berr` or `clr_tmo` clears only its own sticky bit. A clear input held at zero leaves its bit alone. A set in the same cycle as a clear wins.
- R10: A repeated start restarts the bit count, so a repeated start after a complete byte with acknowledge, and the frame that follows it, raise no bus error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_raw | input | 1 | Raw SCL pin level |
| sda_raw | input | 1 | Raw SDA pin level |
| filt_width | input | 8 | Deglitch window in clocks, 0 means 256 |
| to_enable | input | 1 | Timeout watchdog enable |
| to_preset | input | 32 | Timeout threshold in clocks |
| clr_stop | input | 1 | Write-one clear of stat_stop |
| clr_berr | input | 1 | Write-one clear of stat_berr |
| clr_tmo | input | 1 | Write-one clear of stat_tmo |
| scl_f | output | 1 | Filtered SCL |
| sda_f | output | 1 | Filtered SDA |
| scl_rise | output | 1 | One-cycle strobe on filtered SCL rising |
| scl_fall | output | 1 | One-cycle strobe on filtered SCL falling |
| start_pulse | output | 1 | One-cycle start/repeated-start strobe |
| stop_pulse | output | 1 | One-cycle stop strobe |
| bus_busy | output | 1 | High between start and stop |
| stat_stop | output | 1 | Sticky stop-seen status |
| stat_berr | output | 1 | Sticky bus-error status |
| stat_tmo | output | 1 | Sticky SCL timeout status |

## Verification
A raw level change appears on a filtered line 2 + width clocks after it reaches the pin. The matching strobe is high during the next clock, and the sticky bits and `bus_busy` settle one clock after that. The filter checks sample one cycle before and exactly at the due cycle. Bus-sequence checks drive each line step and then wait twelve clocks before sampling, which is well past the six-clock default path. The timeout is checked on both sides of its window: ten clocks short of the preset it must still be clear, and a few clocks past it, it must be set. Strobes are counted at falling clock edges, so each condition must add exactly one count.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    localparam int unsigned WIDTH_BITS   = 8;
    localparam int unsigned TMO_BITS     = 32;
    localparam int unsigned BITS_IN_FRAME = 9;
    localparam int unsigned BITCNT_BITS  = $clog2(BITS_IN_FRAME + 1);

    typedef struct packed {
        logic scl;
        logic sda;
    } lines_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef struct packed {
        logic stop;
        logic berr;
        logic tmo;
    } stat_t;

    // Terminal count of the deglitch counter; 0 wraps to the widest window.
    function automatic logic [WIDTH_BITS-1:0] filt_last(input logic [WIDTH_BITS-1:0] w);
        return w - WIDTH_BITS'(1);
    endfunction

endpackage

// File: rtl/i2cmon_deglitch.sv
module i2cmon_deglitch
    import i2cmon_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  raw,
    input  logic [WIDTH_BITS-1:0] width,
    output logic                  filt
);

    logic                  synced;
    logic [WIDTH_BITS-1:0] run;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            logic [SYNC_STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[SYNC_STAGES-2:0], raw};
            end
            assign synced = chain[SYNC_STAGES-1];
        end else if (SYNC_STAGES == 1) begin : g_single
            logic stage;
            always_ff @(posedge clk) begin
                if (rst) stage <= 1'b1;
                else     stage <= raw;
            end
            assign synced = stage;
        end else begin : g_direct
            assign synced = raw;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            filt <= 1'b1;
            run  <= '0;
        end else if (synced == filt) begin
            run <= '0;
        end else if (run == filt_last(width)) begin
            filt <= synced;
            run  <= '0;
        end else begin
            run <= run + WIDTH_BITS'(1);
        end
    end

endmodule

// File: rtl/i2cmon_condition.sv
module i2cmon_condition
    import i2cmon_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lines_t   cur,
    output bus_evt_t evt,
    output logic     busy,
    output logic     frame_err
);

    localparam logic [BITCNT_BITS-1:0] LAST_BIT  = BITCNT_BITS'(BITS_IN_FRAME);
    localparam logic [BITCNT_BITS-1:0] SAFE_EDGE = BITCNT_BITS'(1);

    lines_t                 prev;
    logic [BITCNT_BITS-1:0] rises;

    always_ff @(posedge clk) begin
        if (rst) prev <= '{scl: 1'b1, sda: 1'b1};
        else     prev <= cur;
    end

    always_comb begin
        evt.scl_rise = cur.scl & ~prev.scl;
        evt.scl_fall = ~cur.scl & prev.scl;
        evt.start    = prev.sda & ~cur.sda & cur.scl & prev.scl;
        evt.stop     = ~prev.sda & cur.sda & cur.scl & prev.scl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
        end else if (evt.start) begin
            busy <= 1'b1;
        end else if (evt.stop) begin
            busy <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || evt.start || evt.stop) begin
            rises <= '0;
        end else if (busy && evt.scl_rise && rises != LAST_BIT) begin
            rises <= rises + BITCNT_BITS'(1);
        end else if (evt.scl_fall && rises == LAST_BIT) begin
            rises <= '0;
        end
    end

    assign frame_err = (evt.start | evt.stop) & busy & (rises > SAFE_EDGE);

endmodule

// File: rtl/i2cmon_watchdog.sv
module i2cmon_watchdog
    import i2cmon_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                active,
    input  logic                scl_edge,
    input  logic [TMO_BITS-1:0] preset,
    output logic                hit
);

    logic [TMO_BITS-1:0] held;

    always_ff @(posedge clk) begin
        if (rst || !active || scl_edge) begin
            held <= '0;
        end else if (held != preset) begin
            held <= held + TMO_BITS'(1);
        end
    end

    assign hit = active & ~scl_edge & (held == preset - TMO_BITS'(1));

endmodule

// File: rtl/i2cmon_top.sv
module i2cmon_top
    import i2cmon_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_raw,
    input  logic                  sda_raw,
    input  logic [WIDTH_BITS-1:0] filt_width,
    input  logic                  to_enable,
    input  logic [TMO_BITS-1:0]   to_preset,
    input  logic                  clr_stop,
    input  logic                  clr_berr,
    input  logic                  clr_tmo,
    output logic                  scl_f,
    output logic                  sda_f,
    output logic                  scl_rise,
    output logic                  scl_fall,
    output logic                  start_pulse,
    output logic                  stop_pulse,
    output logic                  bus_busy,
    output logic                  stat_stop,
    output logic                  stat_berr,
    output logic                  stat_tmo
);

    localparam int unsigned N_LINES = 2;

    logic [N_LINES-1:0] raw_vec;
    logic [N_LINES-1:0] filt_vec;
    lines_t             lines;
    bus_evt_t           evt;
    logic               frame_err;
    logic               tmo_hit;
    stat_t              sticky, set_vec, clr_vec;

    assign raw_vec = {scl_raw, sda_raw};

    generate
        for (genvar i = 0; i < N_LINES; i++) begin : g_line
            i2cmon_deglitch #(.SYNC_STAGES(SYNC_STAGES)) u_flt (
                .clk   (clk),
                .rst   (rst),
                .raw   (raw_vec[i]),
                .width (filt_width),
                .filt  (filt_vec[i])
            );
        end
    endgenerate

    assign lines = '{scl: filt_vec[1], sda: filt_vec[0]};

    i2cmon_condition u_cond (
        .clk       (clk),
        .rst       (rst),
        .cur       (lines),
        .evt       (evt),
        .busy      (bus_busy),
        .frame_err (frame_err)
    );

    i2cmon_watchdog u_wdog (
        .clk      (clk),
        .rst      (rst),
        .active   (to_enable & bus_busy),
        .scl_edge (evt.scl_rise | evt.scl_fall),
        .preset   (to_preset),
        .hit      (tmo_hit)
    );

    assign set_vec = '{stop: evt.stop, berr: frame_err, tmo: tmo_hit};
    assign clr_vec = '{stop: clr_stop, berr: clr_berr, tmo: clr_tmo};

    always_ff @(posedge clk) begin
        if (rst) sticky <= '0;
        else     sticky <= (sticky & ~clr_vec) | set_vec;
    end

    assign scl_f       = lines.scl;
    assign sda_f       = lines.sda;
    assign scl_rise    = evt.scl_rise;
    assign scl_fall    = evt.scl_fall;
    assign start_pulse = evt.start;
    assign stop_pulse  = evt.stop;
    assign stat_stop   = sticky.stop;
    assign stat_berr   = sticky.berr;
    assign stat_tmo    = sticky.tmo;

endmodule

// File: rtl/i2cmon_checker.sv
module i2cmon_checker (
    input logic clk,
    input logic rst,
    input logic scl_f,
    input logic sda_f,
    input logic scl_rise,
    input logic scl_fall,
    input logic start_pulse,
    input logic stop_pulse,
    input logic bus_busy,
    input logic stat_stop,
    input logic stat_tmo,
    input logic clr_stop,
    input logic to_enable
);

    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_pulse, stop_pulse, scl_rise, scl_fall}));

    assert_start_under_high_scl_R4: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> (scl_f && !sda_f));

    assert_busy_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_busy) |-> $past(start_pulse));

    assert_busy_fall_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_busy) |-> $past(stop_pulse));

    assert_stop_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        stop_pulse |=> stat_stop);

    assert_clear_works_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_stop && !stop_pulse) |=> !stat_stop);

    assert_tmo_gated_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_tmo) |-> ($past(to_enable) && $past(bus_busy)));

endmodule

bind i2cmon_top i2cmon_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_f       (scl_f),
    .sda_f       (sda_f),
    .scl_rise    (scl_rise),
    .scl_fall    (scl_fall),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse),
    .bus_busy    (bus_busy),
    .stat_stop   (stat_stop),
    .stat_tmo    (stat_tmo),
    .clr_stop    (clr_stop),
    .to_enable   (to_enable)
);

// File: tb/i2cmon_top_test.sv
`timescale 1ns/1ps
module i2cmon_top_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        scl_raw, sda_raw;
    logic [7:0]  filt_width;
    logic        to_enable;
    logic [31:0] to_preset;
    logic        clr_stop, clr_berr, clr_tmo;
    logic        scl_f, sda_f, scl_rise, scl_fall, start_pulse, stop_pulse;
    logic        bus_busy, stat_stop, stat_berr, stat_tmo;

    int n_cmp = 0;
    int n_bad = 0;
    int n_start = 0, n_stop = 0, n_rise = 0;

    always #2 clk = ~clk;

    i2cmon_top uut (
        .clk(clk), .rst(rst), .scl_raw(scl_raw), .sda_raw(sda_raw),
        .filt_width(filt_width), .to_enable(to_enable), .to_preset(to_preset),
        .clr_stop(clr_stop), .clr_berr(clr_berr), .clr_tmo(clr_tmo),
        .scl_f(scl_f), .sda_f(sda_f), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse), .bus_busy(bus_busy),
        .stat_stop(stat_stop), .stat_berr(stat_berr), .stat_tmo(stat_tmo)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (start_pulse) n_start++;
            if (stop_pulse)  n_stop++;
            if (scl_rise)    n_rise++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic step(input logic scl, input logic sda);
        scl_raw = scl;
        sda_raw = sda;
        idle(12);
    endtask

    task automatic pulses(input int n, input logic sda);
        for (int i = 0; i < n; i++) begin
            step(1'b1, sda);
            step(1'b0, sda);
        end
    endtask

    task automatic clear_all();
        clr_stop = 1'b1; clr_berr = 1'b1; clr_tmo = 1'b1;
        idle(1);
        clr_stop = 1'b0; clr_berr = 1'b0; clr_tmo = 1'b0;
        idle(1);
    endtask

    task automatic t_reset();
        chk("R1 scl_f after reset", scl_f, 1);
        chk("R1 sda_f after reset", sda_f, 1);
        chk("R5 busy after reset", bus_busy, 0);
        chk("R9 sticky after reset", {stat_stop, stat_berr, stat_tmo}, 0);
    endtask

    task automatic t_filter_delay();
        scl_raw = 1'b0;
        idle(5);
        chk("R1 scl_f one clock early", scl_f, 1);
        idle(1);
        chk("R1 scl_f at 2+width", scl_f, 0);
        scl_raw = 1'b1;
        idle(12);
        chk("R1 scl_f back high", scl_f, 1);
    endtask

    task automatic t_glitch();
        sda_raw = 1'b0;
        idle(3);
        sda_raw = 1'b1;
        idle(12);
        chk("R2 short sda glitch ignored", sda_f, 1);
        chk("R2 no start from glitch", n_start, 0);
    endtask

    task automatic t_wide();
        filt_width = 8'd0;
        idle(2);
        scl_raw = 1'b0;
        idle(257);
        chk("R3 width 0 not yet", scl_f, 1);
        idle(1);
        chk("R3 width 0 at 258", scl_f, 0);
        scl_raw = 1'b1;
        idle(260);
        filt_width = 8'd4;
        idle(2);
        chk("R3 restored high", scl_f, 1);
    endtask

    task automatic t_start_stop();
        int s0 = n_start, p0 = n_stop, r0 = n_rise;
        step(1'b1, 1'b0);
        chk("R4 one start strobe", n_start - s0, 1);
        chk("R5 busy after start", bus_busy, 1);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        chk("R4 one rise strobe", n_rise - r0, 1);
        step(1'b1, 1'b1);
        chk("R4 one stop strobe", n_stop - p0, 1);
        chk("R5 idle after stop", bus_busy, 0);
        chk("R6 stop sticky", stat_stop, 1);
        chk("R7 clean frame no error", stat_berr, 0);
    endtask

    task automatic t_clear();
        clr_berr = 1'b1;
        idle(1);
        clr_berr = 1'b0;
        idle(1);
        chk("R9 other clear leaves stop", stat_stop, 1);
        clr_stop = 1'b1;
        idle(1);
        clr_stop = 1'b0;
        idle(1);
        chk("R9 clr_stop clears", stat_stop, 0);
    endtask

    task automatic t_berr_mid();
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        pulses(3, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        chk("R7 stop mid byte errors", stat_berr, 1);
        chk("R6 stop seen", stat_stop, 1);
        chk("R5 busy dropped", bus_busy, 0);
        clear_all();
        chk("R9 all cleared", {stat_stop, stat_berr, stat_tmo}, 0);
    endtask

    task automatic t_berr_ack();
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        pulses(8, 1'b0);
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        chk("R7 start in ack bit errors", stat_berr, 1);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        clear_all();
    endtask

    task automatic t_rstart();
        int s0 = n_start;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        pulses(9, 1'b0);
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        chk("R10 repeated start counted", n_start - s0, 2);
        chk("R10 repeated start no error", stat_berr, 0);
        chk("R10 busy held", bus_busy, 1);
        step(1'b0, 1'b0);
        pulses(9, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        chk("R10 frame after restart clean", stat_berr, 0);
        chk("R5 idle at end", bus_busy, 0);
        clear_all();
    endtask

    task automatic t_timeout();
        to_preset = 32'd40;
        to_enable = 1'b0;
        step(1'b1, 1'b0);
        idle(100);
        chk("R8 disabled no timeout", stat_tmo, 0);
        to_enable = 1'b1;
        idle(30);
        chk("R8 short of preset", stat_tmo, 0);
        idle(15);
        chk("R8 timeout after preset", stat_tmo, 1);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        clear_all();
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        pulses(10, 1'b0);
        chk("R8 toggling SCL no timeout", stat_tmo, 0);
        to_enable = 1'b0;
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        clear_all();
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        scl_raw = 1'b1; sda_raw = 1'b1;
        filt_width = 8'd4;
        to_enable = 1'b0; to_preset = 32'd100000000;
        clr_stop = 1'b0; clr_berr = 1'b0; clr_tmo = 1'b0;
        idle(4);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_filter_delay();
        t_glitch();
        t_wide();
        t_start_stop();
        t_clear();
        t_berr_mid();
        t_berr_ack();
        t_rstart();
        t_timeout();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule